// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-clock synchronous RAM whose read and write transfers can follow each other on every clock with no idle cycle between them. Address, command, chip selects, lane write enables and write data are all taken on the rising clock edge. The write data for a write command is taken two enabled edges after its address edge. Read data is driven over the same bus slot, so a host can mix reads and writes freely. The bidirectional data bus is split into an input bus, an output bus and an output-enable signal.

A command is either loaded from the pins or continued as a four-beat burst. In a burst the two low address bits step through either a linear or an XOR (interleaved) order. A hold input freezes the whole pipeline, the burst state and the array for as long as it is high. The array depth and the lane count and width are parameters. `ADDR_W` must be at least 3.

Top module: `flow_sram`

## Requirements
- R1: During and right after a synchronous reset (`rst_n` low at a rising edge), `dout_en` is low and no burst or command is in flight.
- R2: A read loaded at enabled edge n drives the stored word on `dout` with `dout_en` high in the interval between enabled edges n+1 and n+2, and only in that interval.
- R3: A write loaded at enabled edge n stores the `din` value present at enabled edge n+2. Reads and writes may be issued on consecutive edges in any mix, with no idle cycle.
- R4: Bit i of `lane_wr_n`, taken with the address, enables lane i when it is 0. Lane i is bits [i*LANE_W +: LANE_W]. Lanes whose bit is 1 keep their stored contents.
- R5: A read of an address, issued on the edge right after a write to that address, returns the newly written lanes merged with the old contents of the other lanes.
- R6: While `hold` is 1 at an edge, every input is ignored: no command is taken, no write completes, the burst position does not move, and `dout`/`dout_en` keep their values.
- R7: A loaded command is a deselect unless `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A deselect writes nothing, and `dout_en` is low for its slot two edges later.
- R8: With `burst_next`=1 the previous command (read, write or deselect) continues at the next burst address, ignoring `wr_n`, the selects and `addr`. `lane_wr_n` is still taken fresh on every beat.
- R9: With `order_xor`=0, burst beat k (k=0..3) uses low address bits (base+k) mod 4. The upper bits stay those of the loaded address.
- R10: With `order_xor`=1, burst beat k uses low address bits base XOR k.
- R11: `dout_en` is high only when `out_en_n` is 0 at that moment, even while read data is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | 1 freezes the pipeline and ignores all inputs |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 loads a new command, 1 continues the burst |
| wr_n | input | 1 | 0 write, 1 read (on load) |
| lane_wr_n | input | LANES | Per-lane write enable, active low |
| addr | input | ADDR_W | Word address |
| order_xor | input | 1 | Burst order: 0 linear, 1 XOR |
| out_en_n | input | 1 | Output enable request, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
The bench targets the read of an address on the edge after a write to it with some lanes masked. A design that bypasses nothing would return the stale word; one that forwards the whole word would corrupt the masked lanes. The bench suspends the pipeline with `hold` between a write and its data slot and drives write-like garbage meanwhile. A design that leaks through would store the wrong data, lose the read slot or move the burst. Bursts are run in both orders with `wr_n`, selects and address scrambled on the continue beats, so a design that re-decodes them or steps the wrong bits reads from wrong addresses. Each chip select is dropped alone on a write to show that nothing is stored.

// File: rtl/flow_sram_pkg.sv
// Package: shared command type and burst ordering for the zero-turnaround SRAM.
// Assumes a four-beat burst acting on the two lowest address bits.
package flow_sram_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

    // Low address bits for beat 'step' of a burst starting at 'base'.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] step,
                                            input logic       xor_order);
        return xor_order ? (base ^ step) : (base + step);
    endfunction

endpackage

// File: rtl/flow_sram_burst.sv
// Burst address unit: holds the loaded address and a two-bit beat counter,
// and presents the address of the command now in the first pipeline stage.
// Assumes ADDR_W >= 3 and a static order input during a burst.
module flow_sram_burst
    import flow_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              burst_next,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      base_q;
    logic [1:0]      step_q;

    // Load a new base on a fresh command, otherwise advance the beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            step_q <= '0;
        end else if (en) begin
            if (!burst_next) begin
                hi_q   <= addr_in[ADDR_W-1:2];
                base_q <= addr_in[1:0];
                step_q <= '0;
            end else begin
                step_q <= step_q + 2'd1;
            end
        end
    end

    assign addr_out = {hi_q, burst_lo(base_q, step_q, order_xor)};

    // R9: a linear continue moves the low bits up by one and keeps the rest.
    a_r9_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && burst_next && !order_xor) |=>
        ((addr_out[1:0] == $past(addr_out[1:0]) + 2'd1) &&
         (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]))));

    // R10: an XOR-order continue always moves to a different beat address.
    a_r10_xor_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (en && burst_next && order_xor && $stable(order_xor)) |=>
        (addr_out[1:0] != $past(addr_out[1:0])));

endmodule

// File: rtl/flow_sram_ctrl.sv
// Command pipeline: decodes a loaded command, keeps it across burst beats,
// and carries command, address and lane enables into the second stage.
// Assumes the burst unit supplies the first-stage address.
module flow_sram_ctrl
    import flow_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              burst_next,
    input  logic              sel_all,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] s1_addr,
    output cmd_e              s1_cmd,
    output cmd_e              s2_cmd,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_lane_n
);

    logic [LANES-1:0] s1_lane_n;

    // Advance both stages; a continue beat reuses the stage-one command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_cmd    <= CMD_IDLE;
            s1_lane_n <= '1;
            s2_cmd    <= CMD_IDLE;
            s2_addr   <= '0;
            s2_lane_n <= '1;
        end else if (en) begin
            if (!burst_next) begin
                s1_cmd <= !sel_all ? CMD_IDLE : (wr_n ? CMD_RD : CMD_WR);
            end
            s1_lane_n <= lane_wr_n;
            s2_cmd    <= s1_cmd;
            s2_addr   <= s1_addr;
            s2_lane_n <= s1_lane_n;
        end
    end

    // R7: a load without all three selects yields an idle first stage.
    a_r7_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !burst_next && !sel_all) |=> (s1_cmd == CMD_IDLE));

    // R8: a continue beat keeps the command kind.
    a_r8_cont_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (en && burst_next) |=> (s1_cmd == $past(s1_cmd)));

endmodule

// File: rtl/flow_sram_array.sv
// Storage with per-lane write and a registered read port. A read that meets
// the write completing on the same edge takes the new lanes from wdata.
// Assumes one write and one read per enabled edge.
module flow_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wlane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_word;
    logic              hit;

    assign hit = wr && (waddr == raddr);

    // Commit the enabled lanes of the second-stage write.
    always_ff @(posedge clk) begin
        if (en && wr) begin
            for (int i = 0; i < LANES; i++) begin
                if (!wlane_n[i]) begin
                    mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Per-lane merge of stored and in-flight write data for the read port.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_word[g*LANE_W +: LANE_W] = (hit && !wlane_n[g])
            ? wdata[g*LANE_W +: LANE_W]
            : mem[raddr][g*LANE_W +: LANE_W];
    end

    // Output register of the read path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && rd) begin
            rdata <= rd_word;
        end
    end

    // R5: a full-lane write meeting a read of its address is returned at once.
    a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd && wr && (raddr == waddr) && (wlane_n == '0)) |=>
        (rdata == $past(wdata)));

endmodule

// File: rtl/flow_sram.sv
// Top of the zero-turnaround SRAM: registered inputs, a burst address unit,
// a two-stage command pipeline and the lane-writable array. Writes take
// their data two enabled edges after the address so read and write slots align.
// Assumes order_xor is static during a burst.
module flow_sram
    import flow_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              burst_next,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              order_xor,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              en;
    logic              sel_all;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_lane_n;
    cmd_e              s1_cmd;
    cmd_e              s2_cmd;
    logic              rd_valid;

    assign en      = !hold;
    assign sel_all = !sel_a_n && sel_b && !sel_c_n;

    flow_sram_burst #(.ADDR_W(ADDR_W)) i_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .burst_next (burst_next),
        .order_xor  (order_xor),
        .addr_in    (addr),
        .addr_out   (s1_addr)
    );

    flow_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .burst_next (burst_next),
        .sel_all    (sel_all),
        .wr_n       (wr_n),
        .lane_wr_n  (lane_wr_n),
        .s1_addr    (s1_addr),
        .s1_cmd     (s1_cmd),
        .s2_cmd     (s2_cmd),
        .s2_addr    (s2_addr),
        .s2_lane_n  (s2_lane_n)
    );

    flow_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr      (s2_cmd == CMD_WR),
        .waddr   (s2_addr),
        .wlane_n (s2_lane_n),
        .wdata   (din),
        .rd      (s1_cmd == CMD_RD),
        .raddr   (s1_addr),
        .rdata   (dout)
    );

    // Drive the bus only in a valid read slot with the enable requested.
    assign rd_valid = (s2_cmd == CMD_RD);
    assign dout_en  = rd_valid && !out_en_n;

    // R6: a held edge changes neither the read data nor the read slot.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(dout) && $stable(rd_valid)));

    // R2: a read slot follows an enabled edge at which stage one held a read.
    a_r2_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s1_cmd == CMD_RD) |=> rd_valid);

endmodule

// File: tb/test_flow_sram.sv
// Bench: behavioural reference model updated on every rising edge and
// compared against the outputs at every falling edge.
module test_flow_sram;

    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold = 1'b0;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          burst_next = 1'b0;
    logic          wr_n = 1'b1;
    logic [LN-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic          order_xor = 1'b0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    flow_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_flow_sram (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_next(burst_next), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .order_xor(order_xor),
        .out_en_n(out_en_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    n_cyc = 0;
    string cur_req = "R1";

    // Reference model state: 0 idle, 1 read, 2 write.
    logic [DW-1:0] mm [NW];
    int            p1_cmd = 0, p2_cmd = 0, mb_cmd = 0, mb_step = 0;
    int            p1_addr = 0, p2_addr = 0, mb_base = 0;
    logic [LN-1:0] p1_lane = '1, p2_lane = '1;
    logic          exp_valid = 1'b0;
    logic [DW-1:0] exp_data = '0;

    // Advance the model one edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            p1_cmd = 0; p2_cmd = 0; mb_cmd = 0; mb_step = 0; mb_base = 0;
            exp_valid = 1'b0;
        end else if (!hold) begin
            if (p2_cmd == 2) begin
                for (int i = 0; i < LN; i++)
                    if (!p2_lane[i]) mm[p2_addr][i*LW +: LW] = din[i*LW +: LW];
            end
            exp_valid = (p1_cmd == 1);
            if (p1_cmd == 1) exp_data = mm[p1_addr];
            p2_cmd = p1_cmd; p2_addr = p1_addr; p2_lane = p1_lane;
            if (!burst_next) begin
                if (!sel_a_n && sel_b && !sel_c_n) mb_cmd = wr_n ? 1 : 2;
                else mb_cmd = 0;
                mb_base = int'(addr);
                mb_step = 0;
            end else begin
                mb_step = (mb_step + 1) % 4;
            end
            p1_cmd  = mb_cmd;
            p1_addr = (mb_base & ~3) |
                      (order_xor ? ((mb_base & 3) ^ mb_step) : (((mb_base & 3) + mb_step) % 4));
            p1_lane = lane_wr_n;
        end
    end

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        chk(DW'(dout_en), DW'(exp_valid && !out_en_n), "dout_en");
        if (exp_valid && !out_en_n) chk(dout, exp_data, "dout");
    end

    // Watchdog.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog act=%0d exp<=20000", n_cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // One cycle of stimulus, applied shortly after the rising edge.
    task automatic step(input logic sa, input logic sb, input logic sc, input logic nx,
                        input logic w, input int a, input logic [LN-1:0] ln, input logic h);
        @(posedge clk); #3;
        sel_a_n = sa; sel_b = sb; sel_c_n = sc; burst_next = nx; wr_n = w;
        addr = AW'(a); lane_wr_n = ln; hold = h;
        din = DW'({$urandom, $urandom});
    endtask

    task automatic wr(input int a, input logic [LN-1:0] ln); step(0, 1, 0, 0, 0, a, ln, 0); endtask
    task automatic rd(input int a);                         step(0, 1, 0, 0, 1, a, '1, 0); endtask
    task automatic idle();                                  step(1, 0, 1, 0, 1, 0, '1, 0); endtask
    task automatic cont(input logic [LN-1:0] ln);           step(1, 0, 1, 1, ~wr_n, 33, ln, 0); endtask
    task automatic flush(); for (int i = 0; i < 3; i++) idle(); endtask

    initial begin
        cur_req = "R1";
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, i, '1, 0);
        @(posedge clk); #3; rst_n = 1'b1;
        idle(); idle();

        cur_req = "R3";
        for (int a = 0; a < NW; a++) wr(a, '0);
        flush();
        cur_req = "R2";
        for (int a = NW - 1; a >= 0; a--) rd(a);
        flush();

        cur_req = "R3";
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 0) wr(i, '0); else rd(i + 20);
        end
        for (int i = 0; i < 8; i++) begin
            wr(40 + i, '0); rd(40 + i); rd(i);
        end
        flush();

        cur_req = "R4";
        for (int i = 0; i < 16; i++) wr(48 + (i % 4), 4'(i));
        for (int i = 0; i < 4; i++) rd(48 + i);
        flush();

        cur_req = "R5";
        wr(3, 4'b1010); rd(3);
        wr(4, 4'b0000); rd(4);
        wr(5, 4'b0110); rd(5); rd(5);
        wr(6, 4'b1111); rd(6);
        flush();

        cur_req = "R6";
        rd(7); wr(8, '0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 7, '0, 1);
        rd(8); rd(7);
        rd(9); rd(10);
        step(0, 1, 0, 1, 0, 9, '0, 1);
        step(0, 1, 0, 0, 0, 9, '0, 1);
        rd(11); rd(9);
        flush();

        cur_req = "R7";
        step(1, 1, 0, 0, 0, 12, '0, 0);
        step(0, 0, 0, 0, 0, 12, '0, 0);
        step(0, 1, 1, 0, 0, 12, '0, 0);
        step(1, 1, 0, 0, 1, 12, '1, 0);
        cont('1);
        rd(12);
        flush();

        cur_req = "R8";
        wr(14, '0); cont('0); cont(4'b0011); cont('0);
        step(1, 0, 1, 0, 1, 0, '1, 0);
        cont('0); cont('0);
        cur_req = "R9";
        rd(13); cont('1); cont('1); cont('1); cont('1);
        rd(12); rd(13); rd(14); rd(15);
        flush();

        cur_req = "R10";
        order_xor = 1'b1;
        rd(13); cont('1); cont('1); cont('1);
        wr(18, '0); cont('0); cont('0); cont('0);
        rd(16); rd(17); rd(18); rd(19);
        flush();
        order_xor = 1'b0;

        cur_req = "R11";
        rd(20); rd(21);
        @(posedge clk); #3; out_en_n = 1'b1;
        rd(22); rd(23);
        @(posedge clk); #3; out_en_n = 1'b0;
        rd(24);
        flush();

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule